// File: doc/BRIEF.md
# Boot Source Selector

After reset this controller decides where the chip takes its first program from. While all internal pin drivers stay off, it waits a fixed settling time, then reads once whether pull-up resistors are present on four boot pins: the memory chip-select pin, the clock pin, the SD card chip-select pin and the line the SD card uses as its data input. If the memory chip-select pull-up is missing, no memory boot is tried and the chip goes straight to waiting for a serial download.

When memory is present, the selector starts the flash loader. The flash loader probes the device with a short command/response exchange and reads a block of 256 32-bit words. A checksum unit then judges that block. If the probe or the checksum fails and an SD card is recognised on the same pins, the SD loader is started. If that also fails, or no SD card is seen, the serial-download wait is entered. Before a valid memory image runs, a bounded serial-wait window is opened unless the clock-pin pull-up asks to skip it. A serial download that claims the chip during that window takes precedence over the image.

Top module: `boot_source_sel`

## Requirements
- R1: While reset is asserted and just after it, `src_sel` is 2'b00, `pin_drive_en`, `flash_start`, `sd_start`, `run_image`, `serial_wait` and `sd_di_hold` are all 0.
- R2: `pin_drive_en` stays 0 for exactly SETTLE_CYC+1 clock cycles after reset is released. The four sense inputs are captured once, in the last of those cycles, and any later change on them has no effect on the outcome.
- R3: With no pull-up on the memory chip-select pin (`sense_mem_pu`=0), no loader is started, `src_sel` becomes 2'b11 (serial) and `serial_wait` goes high and stays high.
- R4: With `sense_mem_pu`=1, `flash_start` pulses high for exactly one cycle. At most one loader start strobe is high in any cycle.
- R5: A flash attempt succeeds when `flash_done` arrives with both `flash_ok`=1 and `chk_valid`=1. `src_sel` then becomes 2'b01 (flash).
- R6: A failed flash attempt (either `flash_ok` or `chk_valid` is 0 at `flash_done`) leads to exactly one `sd_start` pulse when an SD card is recognised (`sense_sdcs_pu`=1 and `sense_sddi_pu`=0). Otherwise it leads to serial wait with `src_sel`=2'b11.
- R7: An SD attempt succeeds when `sd_done` arrives with `sd_ok`=1 and `chk_valid`=1, which sets `src_sel`=2'b10 (SD). A failed SD attempt enters serial wait with `src_sel`=2'b11.
- R8: After a successful memory load with the clock-pin pull-up present (`sense_skip_pu`=1), `run_image` pulses once and `serial_wait` never rises.
- R9: After a successful memory load with no clock-pin pull-up, `serial_wait` is high for exactly WIN_CYC cycles, then `run_image` pulses once. If `ser_claim` is high during the window, the selector moves to permanent serial wait, `src_sel` becomes 2'b11 and `run_image` never pulses.
- R10: `sd_di_hold` is high from the `flash_start` cycle until the flash attempt ends, and is low at all other times.
- R11: `run_image` pulses at most once per reset and is never high together with `serial_wait`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sense_mem_pu | input | 1 | Pull-up seen on memory chip-select pin |
| sense_skip_pu | input | 1 | Pull-up seen on clock pin (skip serial window) |
| sense_sdcs_pu | input | 1 | Pull-up seen on SD chip-select pin |
| sense_sddi_pu | input | 1 | Pull-up seen on line shared as SD data input |
| flash_done | input | 1 | Flash loader finished (one cycle) |
| flash_ok | input | 1 | Flash probe answered, qualifies `flash_done` |
| sd_done | input | 1 | SD loader finished (one cycle) |
| sd_ok | input | 1 | SD init and read succeeded, qualifies `sd_done` |
| chk_valid | input | 1 | Checksum of loaded block is valid, sampled with a done |
| ser_claim | input | 1 | Serial host claimed the chip during the window |
| pin_drive_en | output | 1 | Internal pin drivers may be enabled |
| flash_start | output | 1 | One-cycle start strobe to flash loader |
| sd_start | output | 1 | One-cycle start strobe to SD loader |
| sd_di_hold | output | 1 | Keep SD data-input line high |
| src_sel | output | 2 | 00 none, 01 flash, 10 SD, 11 serial |
| run_image | output | 1 | One-cycle strobe to run the loaded image |
| serial_wait | output | 1 | Serial-download wait active |

## Verification
The bench builds the selector with SETTLE_CYC=5 and WIN_CYC=12. These short values let it count the exact length of the driver-off phase and of the serial window, instead of trusting a timeout. Because each scenario resets quickly, every branch of the fallback chain fits into a short run: no memory, flash success with and without the window, flash failure to SD, flash failure with no card, SD failure, and a serial claim inside the window. Sense pins are scrambled after capture to show that only the single sample counts.

// File: rtl/boot_source_sel.sv
module boot_source_sel #(
  parameter int SETTLE_CYC = 64,
  parameter int WIN_CYC    = 50000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sense_mem_pu,
  input  logic       sense_skip_pu,
  input  logic       sense_sdcs_pu,
  input  logic       sense_sddi_pu,
  input  logic       flash_done,
  input  logic       flash_ok,
  input  logic       sd_done,
  input  logic       sd_ok,
  input  logic       chk_valid,
  input  logic       ser_claim,
  output logic       pin_drive_en,
  output logic       flash_start,
  output logic       sd_start,
  output logic       sd_di_hold,
  output logic [1:0] src_sel,
  output logic       run_image,
  output logic       serial_wait
);

  localparam int MAXC = (SETTLE_CYC > WIN_CYC) ? SETTLE_CYC : WIN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] WIN_LAST    = CW'(WIN_CYC - 1);

  localparam logic [1:0] SRC_NONE   = 2'b00;
  localparam logic [1:0] SRC_FLASH  = 2'b01;
  localparam logic [1:0] SRC_SD     = 2'b10;
  localparam logic [1:0] SRC_SERIAL = 2'b11;

  typedef enum logic [3:0] {
    ST_SETTLE, ST_SAMPLE, ST_FL_GO, ST_FL_WAIT, ST_SD_GO, ST_SD_WAIT,
    ST_WINDOW, ST_RUN, ST_SERIAL, ST_DONE
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [1:0]    src_q;
  logic          mem_q, skip_q, sdcs_q, sddi_q;
  logic          card_seen;
  logic          flash_good, sd_good;

  assign card_seen  = sdcs_q & ~sddi_q;
  assign flash_good = flash_done & flash_ok & chk_valid;
  assign sd_good    = sd_done & sd_ok & chk_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_SETTLE;
      cnt    <= '0;
      src_q  <= SRC_NONE;
      mem_q  <= 1'b0;
      skip_q <= 1'b0;
      sdcs_q <= 1'b0;
      sddi_q <= 1'b0;
    end else begin
      case (st)
        ST_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            cnt <= '0;
            st  <= ST_SAMPLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SAMPLE: begin
          mem_q  <= sense_mem_pu;
          skip_q <= sense_skip_pu;
          sdcs_q <= sense_sdcs_pu;
          sddi_q <= sense_sddi_pu;
          if (sense_mem_pu) begin
            st <= ST_FL_GO;
          end else begin
            st    <= ST_SERIAL;
            src_q <= SRC_SERIAL;
          end
        end
        ST_FL_GO: st <= ST_FL_WAIT;
        ST_FL_WAIT: begin
          if (flash_good) begin
            src_q <= SRC_FLASH;
            cnt   <= '0;
            st    <= skip_q ? ST_RUN : ST_WINDOW;
          end else if (flash_done) begin
            if (card_seen) begin
              st <= ST_SD_GO;
            end else begin
              st    <= ST_SERIAL;
              src_q <= SRC_SERIAL;
            end
          end
        end
        ST_SD_GO: st <= ST_SD_WAIT;
        ST_SD_WAIT: begin
          if (sd_good) begin
            src_q <= SRC_SD;
            cnt   <= '0;
            st    <= skip_q ? ST_RUN : ST_WINDOW;
          end else if (sd_done) begin
            st    <= ST_SERIAL;
            src_q <= SRC_SERIAL;
          end
        end
        ST_WINDOW: begin
          if (ser_claim) begin
            st    <= ST_SERIAL;
            src_q <= SRC_SERIAL;
          end else if (cnt == WIN_LAST) begin
            cnt <= '0;
            st  <= ST_RUN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_RUN:    st <= ST_DONE;
        ST_SERIAL: st <= ST_SERIAL;
        default:   st <= ST_DONE;
      endcase
    end
  end

  assign pin_drive_en = (st != ST_SETTLE) && (st != ST_SAMPLE);
  assign flash_start  = (st == ST_FL_GO);
  assign sd_start     = (st == ST_SD_GO);
  assign sd_di_hold   = (st == ST_FL_GO) || (st == ST_FL_WAIT);
  assign run_image    = (st == ST_RUN);
  assign serial_wait  = (st == ST_SERIAL) || (st == ST_WINDOW);
  assign src_sel      = src_q;

  a_r4_one_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_start && sd_start));
  a_r4_flash_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flash_start |=> !flash_start);
  a_r10_hold_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    flash_start |-> sd_di_hold);
  a_r10_hold_off_sd: assert property (@(posedge clk) disable iff (!rst_n)
    sd_start |-> !sd_di_hold);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_image && serial_wait));
  a_r11_run_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    run_image |=> !run_image);
  a_r5_run_source: assert property (@(posedge clk) disable iff (!rst_n)
    run_image |-> (src_sel == SRC_FLASH || src_sel == SRC_SD));
  a_r3_serial_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == SRC_SERIAL) |-> serial_wait);
  a_r2_drivers_off: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_drive_en |-> (src_sel == SRC_NONE && !flash_start));

endmodule

// File: tb/tb_boot_source_sel.sv
module tb_boot_source_sel;
  localparam int SETTLE = 5;
  localparam int WIN    = 12;

  logic clk = 0;
  logic rst_n = 0;
  logic mem_pu = 0, skip_pu = 0, sdcs_pu = 0, sddi_pu = 0;
  logic flash_done = 0, flash_ok = 0, sd_done = 0, sd_ok = 0, chk_valid = 0, ser_claim = 0;
  logic pin_drive_en, flash_start, sd_start, sd_di_hold, run_image, serial_wait;
  logic [1:0] src_sel;

  int checks = 0, failures = 0;
  int n_fs = 0, n_ss = 0, n_run = 0, n_sw = 0;

  always #10 clk = ~clk;

  boot_source_sel #(.SETTLE_CYC(SETTLE), .WIN_CYC(WIN)) dut (
    .clk(clk), .rst_n(rst_n),
    .sense_mem_pu(mem_pu), .sense_skip_pu(skip_pu),
    .sense_sdcs_pu(sdcs_pu), .sense_sddi_pu(sddi_pu),
    .flash_done(flash_done), .flash_ok(flash_ok),
    .sd_done(sd_done), .sd_ok(sd_ok), .chk_valid(chk_valid), .ser_claim(ser_claim),
    .pin_drive_en(pin_drive_en), .flash_start(flash_start), .sd_start(sd_start),
    .sd_di_hold(sd_di_hold), .src_sel(src_sel), .run_image(run_image),
    .serial_wait(serial_wait));

  always @(negedge clk) if (rst_n) begin
    if (flash_start) n_fs++;
    if (sd_start) n_ss++;
    if (run_image) n_run++;
    if (serial_wait) n_sw++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input logic m, input logic s, input logic c, input logic d);
    @(negedge clk);
    rst_n = 0; mem_pu = m; skip_pu = s; sdcs_pu = c; sddi_pu = d;
    flash_done = 0; sd_done = 0; flash_ok = 0; sd_ok = 0; chk_valid = 0; ser_claim = 0;
    repeat (2) @(negedge clk);
    n_fs = 0; n_ss = 0; n_run = 0; n_sw = 0;
    rst_n = 1;
  endtask

  task automatic wait_sig(input int which);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (which == 0 && flash_start) break;
      if (which == 1 && sd_start) break;
    end
  endtask

  task automatic finish_flash(input logic ok, input logic valid);
    repeat (3) @(negedge clk);
    flash_done = 1; flash_ok = ok; chk_valid = valid;
    @(negedge clk);
    flash_done = 0; flash_ok = 0; chk_valid = 0;
  endtask

  task automatic finish_sd(input logic ok, input logic valid);
    repeat (2) @(negedge clk);
    sd_done = 1; sd_ok = ok; chk_valid = valid;
    @(negedge clk);
    sd_done = 0; sd_ok = 0; chk_valid = 0;
  endtask

  task automatic t_reset_and_settle();
    int n;
    @(negedge clk);
    rst_n = 0; mem_pu = 1;
    repeat (2) @(negedge clk);
    chk("R1 src_sel in reset", src_sel, 0);
    chk("R1 strobes in reset", {pin_drive_en, flash_start, sd_start, run_image, serial_wait, sd_di_hold}, 0);
    rst_n = 1;
    n = 0;
    for (int i = 0; i < 50; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (pin_drive_en) break;
    end
    chk("R2 driver-off cycles", n, SETTLE + 1);
  endtask

  task automatic t_no_memory();
    start(0, 1, 1, 0);
    repeat (SETTLE + 6) @(negedge clk);
    chk("R3 src serial", src_sel, 3);
    chk("R3 serial_wait", serial_wait, 1);
    chk("R3 no loader", n_fs + n_ss, 0);
  endtask

  task automatic t_flash_skip();
    start(1, 1, 0, 0);
    wait_sig(0);
    chk("R10 hold at start", sd_di_hold, 1);
    mem_pu = 0; skip_pu = 0; sdcs_pu = 1;
    finish_flash(1, 1);
    chk("R10 hold released", sd_di_hold, 0);
    repeat (4) @(negedge clk);
    chk("R4 single flash pulse", n_fs, 1);
    chk("R5 src flash", src_sel, 1);
    chk("R8 run once", n_run, 1);
    chk("R8 no serial window", n_sw, 0);
    chk("R2 late pin change ignored", n_ss, 0);
  endtask

  task automatic t_flash_window();
    int w;
    start(1, 0, 0, 0);
    wait_sig(0);
    skip_pu = 1;
    finish_flash(1, 1);
    w = 0;
    for (int i = 0; i < 100; i++) begin
      if (run_image) break;
      if (serial_wait) w++;
      @(negedge clk);
    end
    chk("R9 window length", w, WIN);
    @(negedge clk);
    chk("R9 run after window", n_run, 1);
    chk("R11 no serial after run", serial_wait, 0);
  endtask

  task automatic t_flash_fail_sd_ok();
    start(1, 1, 1, 0);
    wait_sig(0);
    finish_flash(1, 0);
    wait_sig(1);
    chk("R6 sd start", n_ss, 1);
    chk("R10 hold low in sd", sd_di_hold, 0);
    finish_sd(1, 1);
    repeat (3) @(negedge clk);
    chk("R7 src sd", src_sel, 2);
    chk("R7 run after sd", n_run, 1);
  endtask

  task automatic t_flash_fail_no_card();
    start(1, 1, 1, 1);
    wait_sig(0);
    finish_flash(0, 1);
    repeat (4) @(negedge clk);
    chk("R6 no sd start", n_ss, 0);
    chk("R6 src serial", src_sel, 3);
    chk("R6 serial_wait", serial_wait, 1);
  endtask

  task automatic t_sd_fail();
    start(1, 0, 1, 0);
    wait_sig(0);
    finish_flash(0, 0);
    wait_sig(1);
    finish_sd(1, 0);
    repeat (4) @(negedge clk);
    chk("R7 sd fail serial", src_sel, 3);
    chk("R7 no run", n_run, 0);
  endtask

  task automatic t_claim();
    start(1, 0, 0, 0);
    wait_sig(0);
    finish_flash(1, 1);
    repeat (4) @(negedge clk);
    ser_claim = 1;
    @(negedge clk);
    ser_claim = 0;
    repeat (WIN + 5) @(negedge clk);
    chk("R9 claim to serial", src_sel, 3);
    chk("R9 claim no run", n_run, 0);
    chk("R11 still serial", serial_wait, 1);
  endtask

  initial begin
    t_reset_and_settle();
    t_no_memory();
    t_flash_skip();
    t_flash_window();
    t_flash_fail_sd_ok();
    t_flash_fail_no_card();
    t_sd_fail();
    t_claim();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule